// File: doc/BRIEF.md
# Multiport FIFO Ready Reporting

This block tells a shared FIFO bus master whether a given network port can take part in a burst. Each port supplies two counts: the free space in its transmit FIFO and the number of stored entries in its receive FIFO. The transmit count is compared against a programmable transmit threshold and the receive count against a separate receive threshold. A port is transmit-ready when its free space reaches the transmit threshold. It is receive-ready when its stored level reaches the receive threshold.

The bus master polls a port by driving the 3-bit port select and pulling the active-low strobe for the direction of interest. The block returns one shared ready flag per direction. That flag is registered, so it shows the answer for the select and strobe sampled at the previous rising clock edge. A deasserted strobe, or a select value beyond the implemented port count, returns a low flag. The block holds no tri-state drivers.

Top module: `fifo_rdy_report`

## Requirements
- R1: One clock edge after sampling tx_strb_ni=0 with port_sel_i=p (p < NUM_PORTS), tx_rdy_o is 1 when tx_free_i[p] >= tx_thr_i and 0 otherwise (unsigned compare).
- R2: One clock edge after sampling rx_strb_ni=0 with port_sel_i=p (p < NUM_PORTS), rx_rdy_o is 1 when rx_fill_i[p] >= rx_thr_i and 0 otherwise (unsigned compare).
- R3: One clock edge after sampling tx_strb_ni=1, tx_rdy_o is 0 regardless of levels, thresholds or select.
- R4: One clock edge after sampling rx_strb_ni=1, rx_rdy_o is 0 regardless of levels, thresholds or select.
- R5: One clock edge after sampling port_sel_i >= NUM_PORTS, both tx_rdy_o and rx_rdy_o are 0.
- R6: Ready outputs change only at rising clock edges; input changes between edges do not affect them until the next edge.
- R7: With a threshold of 0, the selected and strobed port of that direction reports ready at the next edge.
- R8: While rst_ni is 0, both ready outputs are 0.
- R9: The two directions are independent: each flag depends only on its own strobe, level set and threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_free_i | input | NUM_PORTS*LVL_W | Per-port transmit FIFO free space, port p in bits [p*LVL_W +: LVL_W] |
| rx_fill_i | input | NUM_PORTS*LVL_W | Per-port receive FIFO fill level, same packing |
| tx_thr_i | input | LVL_W | Transmit free-space threshold |
| rx_thr_i | input | LVL_W | Receive fill threshold |
| tx_strb_ni | input | 1 | Active-low transmit ready query strobe |
| rx_strb_ni | input | 1 | Active-low receive ready query strobe |
| port_sel_i | input | 3 | Port select |
| tx_rdy_o | output | 1 | Registered transmit-ready flag |
| rx_rdy_o | output | 1 | Registered receive-ready flag |

## Verification
On every cycle, the assertions check three things: the low flag after an idle strobe, the low flags after an out-of-range select, and the forced ready when a threshold is zero. The comparison itself against nonzero thresholds can only be shown by the bench's scenarios. These cover each port at, just below and above threshold. They also cover independence of the two directions and the one-edge latency that holds against input changes between edges.

// File: rtl/fifo_rdy_pkg.sv
package fifo_rdy_pkg;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned MAX_PORTS = 1 << SEL_W;

  typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} rdy_dir_e;
endpackage

// File: rtl/fifo_rdy_cmp.sv
module fifo_rdy_cmp #(
  parameter int unsigned LVL_W = 8
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thr_i,
  output logic             ok_o
);
  assign ok_o = (level_i >= thr_i);
endmodule

// File: rtl/fifo_rdy_sel.sv
module fifo_rdy_sel
  import fifo_rdy_pkg::*;
#(
  parameter int unsigned NUM_PORTS = MAX_PORTS
) (
  input  logic [NUM_PORTS-1:0] ok_i,
  input  logic [SEL_W-1:0]     sel_i,
  output logic                 hit_o
);
  // unimplemented select values match no port, so hit_o stays low
  always_comb begin
    hit_o = 1'b0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (sel_i == SEL_W'(i)) hit_o = ok_i[i];
    end
  end
endmodule

// File: rtl/fifo_rdy_report.sv
module fifo_rdy_report
  import fifo_rdy_pkg::*;
#(
  parameter int unsigned NUM_PORTS = MAX_PORTS,
  parameter int unsigned LVL_W     = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_PORTS-1:0][LVL_W-1:0]   tx_free_i,
  input  logic [NUM_PORTS-1:0][LVL_W-1:0]   rx_fill_i,
  input  logic [LVL_W-1:0]                  tx_thr_i,
  input  logic [LVL_W-1:0]                  rx_thr_i,
  input  logic                              tx_strb_ni,
  input  logic                              rx_strb_ni,
  input  logic [SEL_W-1:0]                  port_sel_i,
  output logic                              tx_rdy_o,
  output logic                              rx_rdy_o
);
  localparam logic [SEL_W:0] PORT_LIM = (SEL_W+1)'(NUM_PORTS);

  logic [NUM_PORTS-1:0] tx_ok, rx_ok;
  logic                 tx_hit, rx_hit;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    fifo_rdy_cmp #(.LVL_W(LVL_W)) u_tx_cmp (
      .level_i(tx_free_i[p]), .thr_i(tx_thr_i), .ok_o(tx_ok[p]));
    fifo_rdy_cmp #(.LVL_W(LVL_W)) u_rx_cmp (
      .level_i(rx_fill_i[p]), .thr_i(rx_thr_i), .ok_o(rx_ok[p]));
  end

  fifo_rdy_sel #(.NUM_PORTS(NUM_PORTS)) u_tx_sel (
    .ok_i(tx_ok), .sel_i(port_sel_i), .hit_o(tx_hit));
  fifo_rdy_sel #(.NUM_PORTS(NUM_PORTS)) u_rx_sel (
    .ok_i(rx_ok), .sel_i(port_sel_i), .hit_o(rx_hit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_rdy_o <= 1'b0;
      rx_rdy_o <= 1'b0;
    end else begin
      tx_rdy_o <= ~tx_strb_ni & tx_hit;
      rx_rdy_o <= ~rx_strb_ni & rx_hit;
    end
  end

  assert_tx_idle_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_strb_ni |=> !tx_rdy_o);
  assert_rx_idle_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_strb_ni |=> !rx_rdy_o);
  assert_unimpl_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, port_sel_i} >= PORT_LIM) |=> (!tx_rdy_o && !rx_rdy_o));
  assert_tx_zero_thr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_thr_i == '0 && !tx_strb_ni && {1'b0, port_sel_i} < PORT_LIM) |=> tx_rdy_o);
  assert_rx_zero_thr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_thr_i == '0 && !rx_strb_ni && {1'b0, port_sel_i} < PORT_LIM) |=> rx_rdy_o);
endmodule

// File: tb/fifo_rdy_report_bench.sv
module fifo_rdy_report_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NP = 6;
  localparam int unsigned LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0][LW-1:0] tx_free, rx_fill;
  logic [LW-1:0] tx_thr, rx_thr;
  logic tx_strb_n, rx_strb_n;
  logic [2:0] sel;
  logic tx_rdy, rx_rdy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_rdy_report #(.NUM_PORTS(NP), .LVL_W(LW)) u_fifo_rdy_report (
    .clk_i(clk), .rst_ni(rst_n), .tx_free_i(tx_free), .rx_fill_i(rx_fill),
    .tx_thr_i(tx_thr), .rx_thr_i(rx_thr), .tx_strb_ni(tx_strb_n),
    .rx_strb_ni(rx_strb_n), .port_sel_i(sel), .tx_rdy_o(tx_rdy), .rx_rdy_o(rx_rdy));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_tx();
    return !tx_strb_n && sel < NP && tx_free[sel] >= tx_thr;
  endfunction
  function automatic logic exp_rx();
    return !rx_strb_n && sel < NP && rx_fill[sel] >= rx_thr;
  endfunction

  // inputs set at negedge; compute expectation, step one edge, sample 1 after
  task automatic step_check(input string req);
    logic et, er;
    et = exp_tx();
    er = exp_rx();
    @(posedge clk); #1;
    check({req, " tx"}, tx_rdy, et);
    check({req, " rx"}, rx_rdy, er);
    @(negedge clk);
  endtask

  task automatic t_reset();
    tx_strb_n = 0; rx_strb_n = 0; sel = 0; tx_thr = 0; rx_thr = 0;
    for (int p = 0; p < NP; p++) begin tx_free[p] = 8'hFF; rx_fill[p] = 8'hFF; end
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R8 tx in reset", tx_rdy, 1'b0);
    check("R8 rx in reset", rx_rdy, 1'b0);
    @(negedge clk); rst_n = 1;
    tx_strb_n = 1; rx_strb_n = 1;
    @(negedge clk);
  endtask

  task automatic t_tx_sweep();
    tx_thr = 8'd40; rx_thr = 8'd200; tx_strb_n = 0; rx_strb_n = 1;
    for (int p = 0; p < NP; p++) tx_free[p] = 8'(38 + p);
    for (int p = 0; p < NP; p++) begin
      sel = 3'(p);
      step_check("R1 sweep");
    end
    tx_free[1] = 8'hFF; sel = 1; step_check("R1 max level");
  endtask

  task automatic t_rx_sweep();
    rx_thr = 8'd100; rx_strb_n = 0; tx_strb_n = 1;
    for (int p = 0; p < NP; p++) rx_fill[p] = 8'(97 + 2*p);
    for (int p = 0; p < NP; p++) begin
      sel = 3'(p);
      step_check("R2 sweep");
    end
    rx_fill[0] = 8'd99; sel = 0; step_check("R2 below by one");
    rx_fill[0] = 8'd100; step_check("R2 equal");
  endtask

  task automatic t_strobe_gate();
    tx_thr = 0; rx_thr = 0; sel = 2;
    tx_strb_n = 1; rx_strb_n = 1; step_check("R3 R4 both idle");
    tx_strb_n = 0; rx_strb_n = 1; step_check("R9 tx only");
    tx_strb_n = 1; rx_strb_n = 0; step_check("R9 rx only");
  endtask

  task automatic t_unimpl();
    tx_thr = 0; rx_thr = 0; tx_strb_n = 0; rx_strb_n = 0;
    sel = 6; step_check("R5 sel6");
    sel = 7; step_check("R5 sel7");
    sel = 5; step_check("R7 last port zero thr");
  endtask

  task automatic t_independent();
    tx_thr = 8'd10; rx_thr = 8'd10; tx_strb_n = 0; rx_strb_n = 0; sel = 3;
    tx_free[3] = 8'd50; rx_fill[3] = 8'd2; step_check("R9 tx hi rx lo");
    tx_free[3] = 8'd2; rx_fill[3] = 8'd50; step_check("R9 tx lo rx hi");
  endtask

  task automatic t_latency();
    tx_thr = 8'd20; rx_thr = 8'd20; tx_strb_n = 0; rx_strb_n = 0; sel = 4;
    tx_free[4] = 8'd30; rx_fill[4] = 8'd30;
    @(posedge clk); #1;
    check("R6 tx after edge", tx_rdy, 1'b1);
    check("R6 rx after edge", rx_rdy, 1'b1);
    tx_free[4] = 8'd5; rx_fill[4] = 8'd5; tx_strb_n = 1;
    #2;
    check("R6 tx holds between edges", tx_rdy, 1'b1);
    check("R6 rx holds between edges", rx_rdy, 1'b1);
    @(posedge clk); #1;
    check("R6 tx next edge", tx_rdy, 1'b0);
    check("R6 rx next edge", rx_rdy, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_tx_sweep();
    t_rx_sweep();
    t_strobe_gate();
    t_unimpl();
    t_independent();
    t_latency();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule